// File: doc/BRIEF.md
# Single-Cycle Unrolled CRC-16 Divider

This unit computes a 16-bit cyclic redundancy remainder for a data operand within one clock cycle. It is intended as a custom operation in a processor execute stage, for example to produce hash indices for membership filters keyed on address prefixes of arbitrary length. The remainder comes from polynomial long division over GF(2). The division is unrolled into one combinational stage per operand bit, with no storage anywhere in the chain.

The operand is `data_i`, with its most significant bit first. A length input says how many leading bits form the message. The unit right-aligns those bits, zero-fills above them and runs them through the divider. Leading zeros with a zero starting remainder leave the result unchanged, so only `len_i` stages have any effect. A select input picks one of two common 16-bit generators.

The combinational remainder is available on `crc_comb_o` in the same cycle. A result register captures it on every clock edge where `issue_i` is high and holds it otherwise.

Top module: `crc16_unit`

## Requirements
- R1: `crc_comb_o` equals the remainder of (message · x^16) divided by the selected generator. The message bits are taken most significant first, the starting remainder is zero, and no output inversion or bit reversal is applied.
- R2: `poly_sel_i` = 0 selects generator x^16+x^15+x^2+1 (low 16 bits 0x8005). `poly_sel_i` = 1 selects x^16+x^12+x^5+1 (low 16 bits 0x1021). A one-bit message of value 1 therefore yields exactly 0x8005 or 0x1021, and a one-bit message of value 0 yields 0x0000.
- R3: For `len_i` = L with 1 ≤ L ≤ DATA_W, the message is `data_i[DATA_W-1 -: L]`. The bits `data_i[DATA_W-L-1:0]` have no effect on the result.
- R4: `len_i` = 0 gives an empty message and a result of 0x0000.
- R5: A `len_i` value greater than DATA_W is treated as DATA_W.
- R6: `crc_comb_o` is a purely combinational function of `data_i`, `len_i` and `poly_sel_i`. It settles in the same cycle the inputs are applied.
- R7: On a rising clock edge with `issue_i` high, `crc_q_o` takes the value `crc_comb_o` had just before that edge.
- R8: On a rising clock edge with `issue_i` low, `crc_q_o` keeps its value.
- R9: While `rst_n` is low, `crc_q_o` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the result register |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Capture the current remainder into `crc_q_o` |
| data_i | input | DATA_W | Operand, message starts at the MSB |
| len_i | input | LEN_W | Number of valid leading bits (0..2^LEN_W-1) |
| poly_sel_i | input | 1 | Generator select: 0 = 0x8005, 1 = 0x1021 |
| crc_comb_o | output | 16 | Same-cycle remainder |
| crc_q_o | output | 16 | Registered remainder |

## Verification
The only state in the block is the result register, but any fault in the division chain shows up on `crc_comb_o` in the same cycle. It reaches `crc_q_o` one edge after the next issue. A stage wired to the wrong bit, or given the wrong generator, corrupts the remainder for most operands. A length-alignment fault shows up when the bits below the valid length are changed. Comparing against an independent bit-serial model across both generators, with lengths from 0 up past DATA_W, exposes these faults at once. A register fault shows up as a value that is stale or changes too early on the edge after an issue.

// File: rtl/crc16_div_pkg.sv
package crc16_div_pkg;

    typedef enum logic {
        POLY_IBM   = 1'b0,
        POLY_CCITT = 1'b1
    } poly_sel_e;

    localparam int unsigned REM_W = 16;

    localparam logic [REM_W-1:0] GEN_IBM_LOW   = 16'h8005;
    localparam logic [REM_W-1:0] GEN_CCITT_LOW = 16'h1021;

    // Low bits of the chosen generator (the x^16 term is implicit).
    function automatic logic [REM_W-1:0] gen_low(input poly_sel_e sel);
        logic [REM_W-1:0] g;
        unique case (sel)
            POLY_IBM:   g = GEN_IBM_LOW;
            POLY_CCITT: g = GEN_CCITT_LOW;
            default:    g = GEN_IBM_LOW;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/crc16_msg_align.sv
module crc16_msg_align #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [DATA_W-1:0] msg_o
);

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DATA_W);

    logic [LEN_W-1:0] eff_len;
    logic [LEN_W-1:0] shift_amt;

    // Clamp oversize lengths, then push the valid MSBs down to bit 0.
    // Bits above the message become zero and leave the remainder unchanged.
    always_comb begin
        eff_len   = (len_i > FULL_LEN) ? FULL_LEN : len_i;
        shift_amt = FULL_LEN - eff_len;
        msg_o     = data_i >> shift_amt;
    end

endmodule

// File: rtl/crc16_div_stage.sv
module crc16_div_stage
    import crc16_div_pkg::*;
(
    input  logic [REM_W-1:0] rem_i,
    input  logic             bit_i,
    input  logic [REM_W-1:0] gen_i,
    output logic [REM_W-1:0] rem_o
);

    logic lead;

    // Leading dividend bit after bringing down one message bit.
    // When it is 1, the generator is subtracted (XOR) beneath it.
    always_comb begin
        lead  = rem_i[REM_W-1] ^ bit_i;
        rem_o = {rem_i[REM_W-2:0], 1'b0} ^ (lead ? gen_i : '0);
    end

endmodule

// File: rtl/crc16_div_chain.sv
module crc16_div_chain
    import crc16_div_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] msg_i,
    input  poly_sel_e         sel_i,
    output logic [REM_W-1:0]  rem_o
);

    logic [REM_W-1:0]           gen;
    logic [DATA_W:0][REM_W-1:0] rem_w;

    assign gen      = gen_low(sel_i);
    assign rem_w[0] = '0;

    // One stage per operand bit, MSB consumed first, no registers between.
    for (genvar k = 0; k < DATA_W; k++) begin : g_stage
        crc16_div_stage u_stage (
            .rem_i (rem_w[k]),
            .bit_i (msg_i[DATA_W-1-k]),
            .gen_i (gen),
            .rem_o (rem_w[k+1])
        );
    end

    assign rem_o = rem_w[DATA_W];

endmodule

// File: rtl/crc16_unit.sv
module crc16_unit
    import crc16_div_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              poly_sel_i,
    output logic [15:0]       crc_comb_o,
    output logic [15:0]       crc_q_o
);

    logic [DATA_W-1:0] msg;
    poly_sel_e         sel;

    assign sel = poly_sel_e'(poly_sel_i);

    crc16_msg_align #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_align (
        .data_i (data_i),
        .len_i  (len_i),
        .msg_o  (msg)
    );

    crc16_div_chain #(
        .DATA_W (DATA_W)
    ) u_chain (
        .msg_i  (msg),
        .sel_i  (sel),
        .rem_o  (crc_comb_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q_o <= '0;
        else if (issue_i)
            crc_q_o <= crc_comb_o;
    end

    // R7
    load_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> crc_q_o == $past(crc_comb_o));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> $stable(crc_q_o));

    // R4
    empty_len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_i == '0) |-> crc_comb_o == 16'h0000);

    // R2
    single_one_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_i == LEN_W'(1) && data_i[DATA_W-1]) |-> crc_comb_o == gen_low(sel));

    // R2
    single_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_i == LEN_W'(1) && !data_i[DATA_W-1]) |-> crc_comb_o == 16'h0000);

endmodule

// File: tb/crc16_unit_tb_top.sv
`timescale 1ns/1ps
module crc16_unit_tb_top;

    localparam int DW = 32;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_i = 1'b0;
    logic [DW-1:0] data_i = '0;
    logic [LW-1:0] len_i = '0;
    logic          poly_sel_i = 1'b0;
    logic [15:0]   crc_comb_o;
    logic [15:0]   crc_q_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    crc16_unit #(.DATA_W(DW), .LEN_W(LW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_i    (issue_i),
        .data_i     (data_i),
        .len_i      (len_i),
        .poly_sel_i (poly_sel_i),
        .crc_comb_o (crc_comb_o),
        .crc_q_o    (crc_q_o)
    );

    // Stimulus table: {poly_sel, len, data}
    localparam int NV = 10;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 6'd32, 32'h3132_3334},
        {1'b1, 6'd32, 32'h3132_3334},
        {1'b0, 6'd8,  32'hFF00_0000},
        {1'b1, 6'd8,  32'hFF00_0000},
        {1'b0, 6'd16, 32'hA5A5_0000},
        {1'b1, 6'd31, 32'hDEAD_BEEF},
        {1'b0, 6'd1,  32'h8000_0000},
        {1'b1, 6'd1,  32'h8000_0000},
        {1'b0, 6'd32, 32'hFFFF_FFFF},
        {1'b1, 6'd24, 32'h0102_0300}
    };

    // Bit-serial shift-register model, MSB first, zero start.
    function automatic logic [15:0] ref_crc(input logic [DW-1:0] d, input int n, input logic s);
        logic [15:0] r;
        logic [15:0] g;
        logic        fb;
        int          m;
        r = 16'h0000;
        g = s ? 16'h1021 : 16'h8005;
        m = (n > DW) ? DW : n;
        for (int i = 0; i < m; i++) begin
            fb = r[15] ^ d[DW-1-i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ g;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at negedge, check combinational output, issue, check register.
    task automatic run_vec(input logic [DW-1:0] d, input int n, input logic s, input string tag);
        logic [15:0] e;
        @(negedge clk);
        data_i     = d;
        len_i      = LW'(n);
        poly_sel_i = s;
        issue_i    = 1'b1;
        e          = ref_crc(d, n, s);
        #1;
        check({tag, " comb R1 R6"}, crc_comb_o, e);
        @(negedge clk);
        issue_i = 1'b0;
        check({tag, " reg R7"}, crc_q_o, e);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        logic [15:0] a_res;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 reset value", crc_q_o, 16'h0000);
        rst_n = 1'b1;

        // R1/R2: table walk
        for (int v = 0; v < NV; v++)
            run_vec(VEC[v][31:0], int'(VEC[v][37:32]), VEC[v][38], "table");

        // R2: single-bit messages give the generator / zero
        run_vec(32'h8000_0000, 1, 1'b0, "R2 ibm gen");
        check("R2 ibm literal", crc_q_o, 16'h8005);
        run_vec(32'h8000_0000, 1, 1'b1, "R2 ccitt gen");
        check("R2 ccitt literal", crc_q_o, 16'h1021);
        run_vec(32'h7FFF_FFFF, 1, 1'b1, "R2 zero bit");
        check("R2 zero literal", crc_q_o, 16'h0000);

        // R4: empty message
        run_vec(32'hCAFE_F00D, 0, 1'b0, "R4 empty");
        check("R4 literal", crc_q_o, 16'h0000);

        // R5: oversize length equals full length
        run_vec(32'h1357_9BDF, 45, 1'b1, "R5 oversize");
        check("R5 vs full", crc_q_o, ref_crc(32'h1357_9BDF, 32, 1'b1));

        // R3: bits below length ignored
        for (int k = 1; k <= 31; k += 5) begin
            logic [DW-1:0] base;
            logic [DW-1:0] mask;
            base = $urandom;
            mask = {DW{1'b1}} >> k;
            run_vec(base & ~mask, k, k[0], "R3 low clear");
            a_res = crc_q_o;
            run_vec(base | mask, k, k[0], "R3 low set");
            check("R3 low bits ignored", crc_q_o, a_res);
        end

        // R8: hold without issue
        run_vec(32'h0BAD_CAFE, 32, 1'b0, "R8 load");
        held = crc_q_o;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            issue_i = 1'b0;
            data_i  = $urandom;
            len_i   = LW'(j + 9);
            @(negedge clk);
            check("R8 hold", crc_q_o, held);
        end

        // R1/R2/R3: random sweep
        for (int t = 0; t < 300; t++) begin
            logic [DW-1:0] d;
            d = $urandom;
            run_vec(d, int'($urandom_range(0, 40)), t[0], "R1 random");
        end

        // R9: reset again clears the register
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 re-reset", crc_q_o, 16'h0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule